// File: doc/BRIEF.md
# SPI Flash Block-Erase Sequencer

This block is the host side of a block erase on an SPI serial flash. A one-cycle `start` pulse hands it a 24-bit byte address and a size select. The size select picks either a 32 KB or a 64 KB block. The block then runs three kinds of chip-select framed transactions on its own.

- The first frame unlocks writes.
- The second frame carries the erase opcode and the block-aligned address.
- By default, further frames read the flash status byte until its busy flag drops.

If `start_timed` was high at the start, the sequencer does not poll. It waits a fixed number of system clocks after the erase frame instead.

The serial clock runs in mode 0. It idles low, data is launched on its falling edge and data is sampled on its rising edge. The serial clock is the system clock divided by `CLK_DIV`, which must be even and at least 2. Chip-select stays high for at least `CS_GAP` system clocks between frames. When the sequence finishes, `done` pulses once. If the busy flag is still set after `POLL_LIMIT` status reads, `done` pulses with `err` raised.

Top module: `blkerase_seq`

## Requirements
- R1: While reset is held and after it, `spi_cs_n` is 1, `spi_sck` is 0, `done` is 0 and `err` is 0.
- R2: An accepted start produces frames in this order:
  - first, an 8-clock frame carrying byte 0x06;
  - second, a 32-clock erase frame;
  - then, in polling mode, 16-clock status frames whose first byte is 0x05.
- R3: The erase frame's first byte is 0x52 when `start_big`=0 and 0xD8 when `start_big`=1. The first byte is followed by the 24-bit address with bits [14:0] forced to zero (32 KB) or bits [15:0] forced to zero (64 KB). All bits are sent MSB first.
- R4: The serial clock is 0 whenever chip-select is high. MOSI changes only while the serial clock is low and holds steady while it is high.
- R5: Within a frame, consecutive rising edges of the serial clock are exactly `CLK_DIV` system clocks apart.
- R6: Between consecutive frames of one sequence, chip-select stays high for at least `CS_GAP` system clocks.
- R7: MISO is sampled on each serial-clock rising edge. The busy flag is bit 0 of the status byte, which is the second byte of a status frame, MSB first.
  - While busy reads 1, another status frame follows.
  - When a read shows 0, `done` pulses with `err`=0, and no further frame is sent.
- R8: If `POLL_LIMIT` status reads in a row all show busy, `done` pulses with `err`=1, the sequencer returns to idle and no further frame is sent. `err` holds until the next accepted start clears it.
- R9: With `start_timed`=1, no status frame is sent. `done` rises exactly `ERASE_CYCLES`+2 system clocks after chip-select rises at the end of the erase frame.
- R10: A `start` pulse that arrives while a sequence is running is ignored. The frames and the completion are unchanged, and no second sequence follows.
- R11: `done` is high for exactly one system clock per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an erase |
| start_addr | input | 24 | Byte address inside the block to erase |
| start_big | input | 1 | 1 selects a 64 KB block, 0 selects a 32 KB block |
| start_timed | input | 1 | 1 waits a fixed time instead of polling status |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Busy never cleared within the poll limit |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip-select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A sequencer state that skips or repeats a step shows up at the pins within one frame. The frame count, frame lengths or leading opcodes differ from the expected sequence as soon as chip-select rises again. A poll counter or busy-bit decode that goes wrong shows up only at completion: `done` arrives after too many or too few status frames, or `err` takes the wrong value. This is why the flash model in the bench answers with a status byte whose other bits are all the inverse of the busy flag. A divider or frame-engine counter fault shows up at the first serial-clock period or inter-frame gap that has the wrong length.

// File: rtl/blkerase_pkg.sv
`timescale 1ns/1ps
package blkerase_pkg;

    localparam logic [7:0] OP_WR_UNLOCK = 8'h06;
    localparam logic [7:0] OP_STATUS    = 8'h05;
    localparam logic [7:0] OP_ERASE_32K = 8'h52;
    localparam logic [7:0] OP_ERASE_64K = 8'hD8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNLOCK,
        SQ_GAP_UL,
        SQ_ERASE,
        SQ_GAP_ST,
        SQ_STATUS,
        SQ_HOLD
    } seq_state_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_LOW,
        EN_HIGH,
        EN_TAIL
    } eng_state_t;

    typedef struct packed {
        logic [23:0] addr;
        logic        big;
        logic        timed;
    } erase_req_t;

    typedef struct packed {
        logic        go;
        logic [5:0]  nbits;
        logic [31:0] word;
    } frame_cmd_t;

    // Erase frame: opcode chosen by size, address aligned to the block.
    function automatic logic [31:0] erase_frame(erase_req_t r);
        logic [23:0] a;
        a = r.addr;
        a[14:0] = '0;
        if (r.big) a[15] = 1'b0;
        return {(r.big ? OP_ERASE_64K : OP_ERASE_32K), a};
    endfunction

endpackage

// File: rtl/blkerase_timer.sv
`timescale 1ns/1ps
module blkerase_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/blkerase_spi_engine.sv
`timescale 1ns/1ps
module blkerase_spi_engine
    import blkerase_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic [5:0]  nbits,
    input  logic [31:0] word,
    input  logic        miso,
    output logic        sck,
    output logic        cs_n,
    output logic        mosi,
    output logic        done,
    output logic [7:0]  rx
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    eng_state_t  st;
    logic [CW-1:0] cnt;
    logic [31:0] shreg;
    logic [5:0]  left;
    logic        tick;

    assign tick = (cnt == CW'(HALF - 1));
    assign mosi = shreg[31];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= EN_IDLE;
            cnt   <= '0;
            shreg <= '0;
            left  <= '0;
            sck   <= 1'b0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
            rx    <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                EN_IDLE: if (go) begin
                    cs_n  <= 1'b0;
                    shreg <= word;
                    left  <= nbits;
                    cnt   <= '0;
                    st    <= EN_LOW;
                end
                EN_LOW: if (tick) begin
                    cnt <= '0;
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                    st  <= EN_HIGH;
                end else cnt <= cnt + 1'b1;
                EN_HIGH: if (tick) begin
                    cnt <= '0;
                    sck <= 1'b0;
                    if (left == 6'd1) st <= EN_TAIL;
                    else begin
                        shreg <= {shreg[30:0], 1'b0};
                        left  <= left - 1'b1;
                        st    <= EN_LOW;
                    end
                end else cnt <= cnt + 1'b1;
                EN_TAIL: if (tick) begin
                    cnt  <= '0;
                    cs_n <= 1'b1;
                    done <= 1'b1;
                    st   <= EN_IDLE;
                end else cnt <= cnt + 1'b1;
                default: st <= EN_IDLE;
            endcase
        end
    end

    // R4
    sck_low_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R4
    mosi_steady_while_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/blkerase_seq.sv
`timescale 1ns/1ps
module blkerase_seq
    import blkerase_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int CS_GAP       = 3,
    parameter int POLL_LIMIT   = 6,
    parameter int ERASE_CYCLES = 300
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [23:0] start_addr,
    input  logic        start_big,
    input  logic        start_timed,
    output logic        done,
    output logic        err,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int TMAX = (CS_GAP > ERASE_CYCLES) ? CS_GAP : ERASE_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PCW  = $clog2(POLL_LIMIT + 1);

    seq_state_t  state, nxt;
    erase_req_t  req_q;
    frame_cmd_t  cmd;
    logic [PCW-1:0] poll_cnt;
    logic [TW-1:0]  tmr_val;
    logic tmr_ld, tmr_zero;
    logic eng_done;
    logic [7:0] eng_rx;
    logic take, set_done, set_err, poll_inc, poll_clr;

    blkerase_spi_engine #(.CLK_DIV(CLK_DIV)) u_engine (
        .clk(clk), .rst(rst), .go(cmd.go), .nbits(cmd.nbits), .word(cmd.word),
        .miso(spi_miso), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .done(eng_done), .rx(eng_rx)
    );

    blkerase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_ld), .val(tmr_val), .zero(tmr_zero)
    );

    always_comb begin
        nxt      = state;
        cmd      = '0;
        tmr_ld   = 1'b0;
        tmr_val  = '0;
        take     = 1'b0;
        set_done = 1'b0;
        set_err  = 1'b0;
        poll_inc = 1'b0;
        poll_clr = 1'b0;
        case (state)
            SQ_IDLE: if (start) begin
                take      = 1'b1;
                cmd.go    = 1'b1;
                cmd.nbits = 6'd8;
                cmd.word  = {OP_WR_UNLOCK, 24'h0};
                nxt       = SQ_UNLOCK;
            end
            SQ_UNLOCK: if (eng_done) begin
                tmr_ld  = 1'b1;
                tmr_val = TW'(CS_GAP);
                nxt     = SQ_GAP_UL;
            end
            SQ_GAP_UL: if (tmr_zero) begin
                cmd.go    = 1'b1;
                cmd.nbits = 6'd32;
                cmd.word  = erase_frame(req_q);
                nxt       = SQ_ERASE;
            end
            SQ_ERASE: if (eng_done) begin
                tmr_ld = 1'b1;
                if (req_q.timed) begin
                    tmr_val = TW'(ERASE_CYCLES);
                    nxt     = SQ_HOLD;
                end else begin
                    tmr_val  = TW'(CS_GAP);
                    poll_clr = 1'b1;
                    nxt      = SQ_GAP_ST;
                end
            end
            SQ_GAP_ST: if (tmr_zero) begin
                cmd.go    = 1'b1;
                cmd.nbits = 6'd16;
                cmd.word  = {OP_STATUS, 24'h0};
                nxt       = SQ_STATUS;
            end
            SQ_STATUS: if (eng_done) begin
                if (!eng_rx[0]) begin
                    set_done = 1'b1;
                    nxt      = SQ_IDLE;
                end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                    set_done = 1'b1;
                    set_err  = 1'b1;
                    nxt      = SQ_IDLE;
                end else begin
                    poll_inc = 1'b1;
                    tmr_ld   = 1'b1;
                    tmr_val  = TW'(CS_GAP);
                    nxt      = SQ_GAP_ST;
                end
            end
            SQ_HOLD: if (tmr_zero) begin
                set_done = 1'b1;
                nxt      = SQ_IDLE;
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            req_q    <= '0;
            poll_cnt <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            state <= nxt;
            done  <= set_done;
            if (take) begin
                req_q <= '{addr: start_addr, big: start_big, timed: start_timed};
                err   <= 1'b0;
            end
            if (set_err) err <= 1'b1;
            if (take || poll_clr) poll_cnt <= '0;
            else if (poll_inc)    poll_cnt <= poll_cnt + 1'b1;
        end
    end

    // R11
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        poll_cnt < PCW'(POLL_LIMIT));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && state != SQ_IDLE) |=> $stable(req_q));

    // R6
    gap_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_GAP_UL || state == SQ_GAP_ST || state == SQ_HOLD) |-> spi_cs_n);
endmodule

// File: tb/blkerase_seq_bench.sv
`timescale 1ns/1ps
module blkerase_seq_bench;
    localparam int CLK_DIV      = 4;
    localparam int CS_GAP       = 3;
    localparam int POLL_LIMIT   = 6;
    localparam int ERASE_CYCLES = 300;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [23:0] start_addr = '0;
    logic start_big = 1'b0, start_timed = 1'b0;
    logic miso = 1'b0;
    logic done, err, sck, cs_n, mosi;

    always #2.5 clk = ~clk;

    blkerase_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT),
                   .ERASE_CYCLES(ERASE_CYCLES)) u_blkerase_seq (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_big(start_big), .start_timed(start_timed), .done(done), .err(err),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Flash model and pin monitor, evaluated away from the active edge
    logic [31:0] fr_data [0:31];
    int          fr_bits [0:31];
    int fr_n = 0, nb = 0, gap = 0, min_gap = 1000000;
    int viol_mode = 0, viol_per = 0, last_rise = 0, busy_left = 0, cs_rise_cyc = 0;
    logic [31:0] cur = '0;
    logic [7:0]  cur_op = '0, stat;
    logic p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            stat = (busy_left > 0) ? 8'h01 : 8'hFE;
            if (sck && p_sck && mosi !== p_mosi) viol_mode++;
            if (sck && cs_n) viol_mode++;
            if (p_cs && !cs_n) begin
                if (fr_n > 0 && gap < min_gap) min_gap = gap;
                cur = '0; nb = 0; cur_op = '0;
            end
            if (cs_n) gap++; else gap = 0;
            if (sck && !p_sck) begin
                if (nb > 0 && cyc - last_rise != CLK_DIV) viol_per++;
                last_rise = cyc;
                cur = {cur[30:0], mosi};
                nb++;
                if (nb == 8) cur_op = cur[7:0];
            end
            if (!sck && p_sck && cur_op == 8'h05 && nb >= 8 && nb < 16)
                miso = stat[15 - nb];
            if (!p_cs && cs_n) begin
                if (fr_n < 32) begin
                    fr_data[fr_n] = cur;
                    fr_bits[fr_n] = nb;
                end
                fr_n++;
                cs_rise_cyc = cyc;
                if (cur_op == 8'h05 && nb == 16 && busy_left > 0) busy_left--;
                miso = 1'b0;
            end
        end
        p_sck  = sck;
        p_cs   = cs_n;
        p_mosi = mosi;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0, "R1 pins idle in reset", {cs_n, sck}, 2'b10);
        chk(done == 1'b0 && err == 1'b0, "R1 flags low in reset", {done, err}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && done == 1'b0 && err == 1'b0, "R1 idle after reset",
            {cs_n, done, err}, 3'b100);
    endtask

    task automatic run_seq(input logic [23:0] addr, input bit big, input bit timed,
                           input int busy, input bit exp_err, input bit disturb);
        int n, exp_frames, done_cyc;
        logic [23:0] ea;
        logic [7:0]  eop;
        fr_n = 0; min_gap = 1000000; viol_mode = 0; viol_per = 0; busy_left = busy;
        @(negedge clk);
        start_addr = addr; start_big = big; start_timed = timed; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b0, "R8 err cleared by accepted start", err, 0);
        if (disturb) begin
            repeat (30) @(negedge clk);
            start_addr = ~addr; start_big = ~big; start_timed = ~timed; start = 1'b1;
            @(negedge clk);
            start = 1'b0; start_timed = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        done_cyc = cyc;
        chk(done == 1'b1, "R7 done reached", done, 1);
        chk(err == exp_err, "R8 err at completion", err, exp_err);
        if (timed)
            chk(done_cyc - cs_rise_cyc == ERASE_CYCLES + 2, "R9 timed wait length",
                done_cyc - cs_rise_cyc, ERASE_CYCLES + 2);
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", done, 0);
        repeat (60) @(negedge clk);
        exp_frames = timed ? 2 : (exp_err ? 2 + POLL_LIMIT : 3 + busy);
        chk(fr_n == exp_frames, disturb ? "R10 frame count with stray start" : "R2 frame count",
            fr_n, exp_frames);
        chk(cs_n == 1'b1, "R10 no further frame", cs_n, 1);
        chk(fr_bits[0] == 8 && fr_data[0][7:0] == 8'h06, "R2 unlock frame",
            fr_data[0][7:0], 8'h06);
        ea  = addr & (big ? 24'hFF0000 : 24'hFF8000);
        eop = big ? 8'hD8 : 8'h52;
        chk(fr_bits[1] == 32 && fr_data[1] == {eop, ea}, "R3 erase frame",
            fr_data[1], {eop, ea});
        for (int i = 2; i < fr_n && i < 32; i++)
            chk(fr_bits[i] == 16 && fr_data[i][15:8] == 8'h05, "R7 status frame",
                {fr_bits[i][7:0], fr_data[i][15:8]}, 16'h1005);
        chk(min_gap >= CS_GAP, "R6 deselect gap", min_gap, CS_GAP);
        chk(viol_mode == 0, "R4 mode 0 timing", viol_mode, 0);
        chk(viol_per == 0, "R5 serial clock period", viol_per, 0);
    endtask

    task automatic test_err_hold();
        repeat (20) @(negedge clk);
        chk(err == 1'b1, "R8 err held while idle", err, 1);
        chk(cs_n == 1'b1, "R8 no frame after error", cs_n, 1);
    endtask

    initial begin
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        run_seq(24'h12ABCD, 1'b0, 1'b0, 2, 1'b0, 1'b0);   // 32 KB, two busy reads
        run_seq(24'hFEDCBA, 1'b1, 1'b0, 0, 1'b0, 1'b0);   // 64 KB, ready at once
        run_seq(24'h07FFFF, 1'b0, 1'b0, 100, 1'b1, 1'b0); // poll limit
        test_err_hold();
        run_seq(24'h0F1234, 1'b1, 1'b1, 0, 1'b0, 1'b0);   // timed wait
        run_seq(24'h3C8001, 1'b0, 1'b0, 1, 1'b0, 1'b1);   // stray start
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule